// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block holds the configuration for the reset pulse that a watchdog sends off chip when it expires, and it generates that pulse. A single 32-bit register sets three things: how long the pulse lasts, which level counts as asserted, and whether the output is always driven or only pulled during the pulse. The pulse length is counted in microsecond ticks, which the block takes as a one-cycle strobe from outside. The expiry event is another one-cycle strobe.

The two mode bits are protected against stray writes. They read back as plain bits, but a write changes them only when the top byte of the write data is one of four key codes. The low width field is taken from every write, whatever the top byte holds. The outputs are a level and an output enable. A pad wrapper turns that pair into a push-pull or an open-drain pin. The reduced variant is chosen by a parameter and narrows the width field from 20 bits to 8.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0x000000FF: active-low polarity, open-drain drive, width 0xFF. No pulse is running, so `pulse_out` is 1 and `pulse_oe` is 0.
- R2: On a read, bit 31 is the polarity (1 = active-high) and bit 30 is the drive mode (1 = push-pull). The width is in bits [W-1:0], where W is 20, or 8 when `NARROW` is set. Every other bit reads 0, and the read value changes only on a write.
- R3: Every write loads bits [W-1:0] of the write data into the width field, whatever the top byte holds. The new value reads back from the next cycle.
- R4: A write whose bits [31:24] equal 0xA5 sets the polarity to active-high. A write whose bits [31:24] equal 0x5A sets it to active-low.
- R5: A write whose bits [31:24] equal 0xA8 selects push-pull drive. A write whose bits [31:24] equal 0x8A selects open-drain drive.
- R6: A write with any other top byte leaves bits 31 and 30 unchanged.
- R7: An expiry strobe that arrives with no pulse running starts a pulse from the next cycle. The pulse holds the width value N that was in the register in the strobe cycle, including when a write lands in that same cycle. The pulse ends at the clock edge that samples the (N+1)-th `tick_us` strobe after the start, so 0 gives one tick.
- R8: An expiry strobe that arrives while a pulse is running is ignored. This includes the cycle in which the last tick ends the pulse. The pulse is neither restarted nor extended.
- R9: While a pulse runs, `pulse_out` equals the polarity bit. Otherwise it is the inverse of the polarity bit. `pulse_oe` is always 1 in push-pull mode. In open-drain mode it is 1 only while a pulse runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read value |
| expire | input | 1 | Watchdog expiry strobe, one cycle |
| tick_us | input | 1 | One-microsecond tick strobe, one cycle |
| pulse_out | output | 1 | Reset pulse level |
| pulse_oe | output | 1 | Output enable for the pulse pin |

## Verification
Two functions can coincide. A register write can land in the same cycle as an expiry strobe. An expiry strobe can also land in the cycle where the final tick ends a pulse. The bench provokes the first by issuing a width write and an expiry together, and checks that the pulse length follows the old width. It provokes the second by holding expiry high across whole pulses, and checks that each pulse ends on time and that a new one starts only in the following cycle. A behavioural model in the bench judges every cycle: it compares the read value, the output level and the output enable.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    localparam int REG_W     = 32;
    localparam int KEY_W     = 8;
    localparam int WIDE_W    = 20;
    localparam int SLIM_W    = 8;
    localparam int POL_BIT   = 31;
    localparam int DRV_BIT   = 30;
    localparam int RST_WIDTH = 255;

    localparam logic [KEY_W-1:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [KEY_W-1:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [KEY_W-1:0] KEY_DRV_PUSH = 8'hA8;
    localparam logic [KEY_W-1:0] KEY_DRV_OPEN = 8'h8A;

    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;

    typedef enum logic {
        DRV_OPEN = 1'b0,
        DRV_PUSH = 1'b1
    } drv_e;

    // Update request produced by the key decoder
    typedef struct packed {
        logic pol_upd;
        pol_e pol_new;
        logic drv_upd;
        drv_e drv_new;
    } key_act_t;

    // Mode bits carried to the output stage
    typedef struct packed {
        pol_e pol;
        drv_e drv;
    } mode_t;

    function automatic key_act_t decode_key(input logic [KEY_W-1:0] b);
        key_act_t a;
        a = '{pol_upd: 1'b0, pol_new: POL_LOW, drv_upd: 1'b0, drv_new: DRV_OPEN};
        unique case (b)
            KEY_POL_HIGH: begin a.pol_upd = 1'b1; a.pol_new = POL_HIGH; end
            KEY_POL_LOW:  begin a.pol_upd = 1'b1; a.pol_new = POL_LOW;  end
            KEY_DRV_PUSH: begin a.drv_upd = 1'b1; a.drv_new = DRV_PUSH; end
            KEY_DRV_OPEN: begin a.drv_upd = 1'b1; a.drv_new = DRV_OPEN; end
            default: ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/rpc_key_decode.sv
module rpc_key_decode
    import rpc_pkg::*;
(
    input  logic             wr,
    input  logic [KEY_W-1:0] key_byte,
    output key_act_t         act
);

    key_act_t raw;

    always_comb begin
        raw = decode_key(key_byte);
        act = raw;
        if (!wr) begin
            act.pol_upd = 1'b0;
            act.drv_upd = 1'b0;
        end
    end

endmodule

// File: rtl/rpc_cfg_reg.sv
module rpc_cfg_reg
    import rpc_pkg::*;
#(
    parameter int WIDTH_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [WIDTH_W-1:0] wdata_width,
    input  key_act_t           act,
    output mode_t              mode,
    output logic [WIDTH_W-1:0] width,
    output logic [REG_W-1:0]   rdata
);

    localparam int PAD_W = REG_W - 2 - WIDTH_W;
    localparam logic [WIDTH_W-1:0] WIDTH_DEF = WIDTH_W'(RST_WIDTH);

    mode_t              mode_q;
    logic [WIDTH_W-1:0] width_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '{pol: POL_LOW, drv: DRV_OPEN};
            width_q <= WIDTH_DEF;
        end else begin
            if (wr) begin
                width_q <= wdata_width;
            end
            if (act.pol_upd) begin
                mode_q.pol <= act.pol_new;
            end
            if (act.drv_upd) begin
                mode_q.drv <= act.drv_new;
            end
        end
    end

    assign mode  = mode_q;
    assign width = width_q;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = {logic'(mode_q.pol), logic'(mode_q.drv), {PAD_W{1'b0}}, width_q};
        end else begin : g_nopad
            assign rdata = {logic'(mode_q.pol), logic'(mode_q.drv), width_q};
        end
    endgenerate

endmodule

// File: rtl/rpc_pulse_gen.sv
module rpc_pulse_gen #(
    parameter int WIDTH_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               expire,
    input  logic [WIDTH_W-1:0] width,
    output logic               active
);

    logic               act_q;
    logic [WIDTH_W-1:0] cnt_q;
    logic [WIDTH_W-1:0] len_q;
    logic               last_tick;

    assign last_tick = tick && (cnt_q == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            len_q <= '0;
        end else if (act_q) begin
            if (last_tick) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (expire) begin
            act_q <= 1'b1;
            cnt_q <= '0;
            len_q <= width;
        end
    end

    assign active = act_q;

endmodule

// File: rtl/rpc_out_stage.sv
module rpc_out_stage
    import rpc_pkg::*;
(
    input  mode_t mode,
    input  logic  active,
    output logic  level,
    output logic  oe
);

    always_comb begin
        level = active ? logic'(mode.pol) : ~logic'(mode.pol);
        oe    = (mode.drv == DRV_PUSH) || active;
    end

endmodule

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl
    import rpc_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             expire,
    input  logic             tick_us,
    output logic             pulse_out,
    output logic             pulse_oe
);

    localparam int WIDTH_W = NARROW ? SLIM_W : WIDE_W;

    key_act_t           key_act;
    mode_t              mode;
    logic [WIDTH_W-1:0] width;
    logic               pulse_active;

    rpc_key_decode u_key (
        .wr       (bus_wr),
        .key_byte (bus_wdata[REG_W-1 -: KEY_W]),
        .act      (key_act)
    );

    rpc_cfg_reg #(.WIDTH_W(WIDTH_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr          (bus_wr),
        .wdata_width (bus_wdata[WIDTH_W-1:0]),
        .act         (key_act),
        .mode        (mode),
        .width       (width),
        .rdata       (bus_rdata)
    );

    rpc_pulse_gen #(.WIDTH_W(WIDTH_W)) u_gen (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_us),
        .expire (expire),
        .width  (width),
        .active (pulse_active)
    );

    rpc_out_stage u_out (
        .mode   (mode),
        .active (pulse_active),
        .level  (pulse_out),
        .oe     (pulse_oe)
    );

endmodule

// File: rtl/rst_pulse_ctrl_chk.sv
module rst_pulse_ctrl_chk
    import rpc_pkg::*;
#(
    parameter int WIDTH_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic             expire,
    input logic             tick_us,
    input logic             pulse_out,
    input logic             pulse_oe,
    input logic             active
);

    logic [KEY_W-1:0] top;
    logic             is_key;

    assign top    = bus_wdata[REG_W-1 -: KEY_W];
    assign is_key = (top == KEY_POL_HIGH) || (top == KEY_POL_LOW) ||
                    (top == KEY_DRV_PUSH) || (top == KEY_DRV_OPEN);

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DRV_BIT-1:WIDTH_W] == '0);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(bus_rdata));

    assert_width_R3: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> bus_rdata[WIDTH_W-1:0] == $past(bus_wdata[WIDTH_W-1:0]));

    assert_key_high_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && top == KEY_POL_HIGH) |=> bus_rdata[POL_BIT]);

    assert_key_low_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && top == KEY_POL_LOW) |=> !bus_rdata[POL_BIT]);

    assert_key_push_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && top == KEY_DRV_PUSH) |=> bus_rdata[DRV_BIT]);

    assert_key_open_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && top == KEY_DRV_OPEN) |=> !bus_rdata[DRV_BIT]);

    assert_no_key_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !is_key) |=> $stable(bus_rdata[POL_BIT:DRV_BIT]));

    assert_start_R7: assert property (@(posedge clk) disable iff (rst)
        (!active && expire) |=> active);

    assert_end_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(tick_us));

    assert_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (active && expire && !tick_us) |=> active);

    assert_oe_push_R9: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DRV_BIT] |-> pulse_oe);

    assert_oe_open_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_rdata[DRV_BIT] |-> (pulse_oe == active));

    assert_level_R9: assert property (@(posedge clk) disable iff (rst)
        pulse_out == (active ? bus_rdata[POL_BIT] : !bus_rdata[POL_BIT]));

endmodule

bind rst_pulse_ctrl rst_pulse_ctrl_chk #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .expire    (expire),
    .tick_us   (tick_us),
    .pulse_out (pulse_out),
    .pulse_oe  (pulse_oe),
    .active    (pulse_active)
);

// File: tb/sim_rst_pulse_ctrl.sv
module sim_rst_pulse_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        expire = 1'b0;
    logic        tick_us = 1'b0;
    logic        pulse_out;
    logic        pulse_oe;

    always #2.5 clk = ~clk;

    rst_pulse_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .expire(expire), .tick_us(tick_us),
        .pulse_out(pulse_out), .pulse_oe(pulse_oe)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    run_cmp = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_pol, m_drv, m_width, m_act, m_cnt, m_len;
    int tick_div = 0;

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // tick generator: one strobe every third cycle
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 3;
        tick_us <= (tick_div == 0);
    end

    always @(posedge clk) begin
        if (rst) begin
            m_pol = 0; m_drv = 0; m_width = 32'hFF; m_act = 0; m_cnt = 0; m_len = 0;
        end else begin
            if (m_act != 0) begin
                if (tick_us) begin
                    if (m_cnt == m_len) m_act = 0;
                    else m_cnt++;
                end
            end else if (expire) begin
                m_act = 1; m_cnt = 0; m_len = m_width;
            end
            if (bus_wr) begin
                m_width = bus_wdata & 32'h000F_FFFF;
                case (bus_wdata[31:24])
                    8'hA5: m_pol = 1;
                    8'h5A: m_pol = 0;
                    8'hA8: m_drv = 1;
                    8'h8A: m_drv = 0;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (run_cmp && !rst) begin
            check(cur_req, "rdata", bus_rdata,
                  (longint'(m_pol) << 31) | (longint'(m_drv) << 30) | m_width);
            check((cur_req == "R1") ? "R1" : "R9", "pulse_out", pulse_out,
                  (m_act != 0) ? m_pol : 1 - m_pol);
            check((cur_req == "R1") ? "R1" : "R9", "pulse_oe", pulse_oe,
                  ((m_drv != 0) || (m_act != 0)) ? 1 : 0);
        end
    end

    task automatic cyc(bit w, logic [31:0] d, bit e);
        @(negedge clk);
        bus_wr = w; bus_wdata = d; expire = e;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 32'h0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    int plen;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1", "reset rdata", bus_rdata, 32'h0000_00FF);
        check("R1", "reset out", pulse_out, 1);
        check("R1", "reset oe", pulse_oe, 0);
        run_cmp = 1;

        cur_req = "R3";
        cyc(1, 32'h0000_0003, 0);
        cyc(1, 32'h3FF0_0005, 0);          // R2: pad bits must read zero
        idle(2);
        check("R2", "pad bits zero", bus_rdata[29:20], 0);

        cur_req = "R4";
        cyc(1, 32'hA500_0002, 0);
        idle(1);
        check("R4", "polarity high", bus_rdata[31], 1);
        cur_req = "R5";
        cyc(1, 32'hA800_0002, 0);
        idle(1);
        check("R5", "push-pull", bus_rdata[30], 1);

        cur_req = "R6";
        cyc(1, 32'hFF00_0004, 0);
        cyc(1, 32'hA600_0004, 0);
        cyc(1, 32'h5B00_0004, 0);
        cyc(1, 32'h8B00_0002, 0);
        idle(1);
        check("R6", "mode bits held", bus_rdata[31:30], 2'b11);

        // R7: pulse, with a width change during it; R8: repeated expiry ignored
        cur_req = "R7";
        cyc(0, 0, 1);
        cyc(1, 32'h0000_0009, 0);
        cur_req = "R8";
        for (int i = 0; i < 4; i++) cyc(0, 0, 1);
        idle(20);

        // R7: write coinciding with expiry, pulse keeps old width (9)
        cur_req = "R7";
        cyc(1, 32'h0000_0000, 1);
        plen = 0;
        for (int i = 0; i < 60; i++) begin
            cyc(0, 0, 0);
            if (pulse_out == 1'b1) plen++;
        end
        check("R7", "old width used, long pulse", (plen > 20) ? 1 : 0, 1);

        // R8: expiry held high across pulses, including the final-tick cycle
        cur_req = "R8";
        for (int i = 0; i < 30; i++) cyc(0, 0, 1);
        idle(6);

        // R9: open-drain active-low
        cur_req = "R9";
        cyc(1, 32'h5A00_0001, 0);
        cyc(1, 32'h8A00_0001, 0);
        idle(2);
        check("R9", "released oe", pulse_oe, 0);
        cyc(0, 0, 1);
        idle(1);
        check("R9", "asserted low", pulse_out, 0);
        check("R9", "asserted oe", pulse_oe, 1);
        idle(10);

        // R7: width 0 gives one tick, back-to-back expiry
        cur_req = "R7";
        cyc(1, 32'h0000_0000, 0);
        for (int i = 0; i < 12; i++) cyc(0, 0, 1);
        cyc(1, 32'hA5FF_FFFF, 0);
        cyc(0, 0, 1);
        idle(3200);

        idle(2);
        finish_run();
    end

endmodule